// File: doc/BRIEF.md
# Keyboard Controller Host Interface

This block is the host-facing register window of a keyboard controller. The host sees two I/O addresses. The data port (0x60) and the command port (0x64) both accept writes into a one-byte input buffer. A read of the data port returns the one-byte output buffer. A read of the command port returns an eight-bit status byte. On the other side, the controller firmware consumes the input byte. It learns from a flag whether the byte arrived as a command or as data. It loads bytes for the host, reports a passed self test, writes the system flag, and reports how each serial transmit to the keyboard ended.

Three small state machines carry the behaviour. The input buffer machine has the states IB_EMPTY and IB_HELD. A host write takes it from IB_EMPTY to IB_HELD. A controller take without a host write in the same cycle takes it back to IB_EMPTY. The output buffer machine has the states OB_EMPTY and OB_HELD. A controller load takes it from OB_EMPTY to OB_HELD. A host data-port read without a load in the same cycle takes it back to OB_EMPTY. The transmit machine has the states TX_IDLE and TX_WAIT. A transmit start takes it from TX_IDLE to TX_WAIT and clears the error flags. A reported result takes it from TX_WAIT back to TX_IDLE and records the outcome. A start during TX_WAIT keeps it in TX_WAIT.

Status byte layout, from bit 7 down to bit 0:

| Bit | Meaning |
|-----|---------|
| 7 | parity error |
| 6 | receive timeout |
| 5 | transmit timeout |
| 4 | inhibit switch sample, 0 = inhibited |
| 3 | last write was to the command port |
| 2 | system flag |
| 1 | input buffer full |
| 0 | output buffer full |

Top module: `kbc_host_port`

## Requirements
- R1: A host write to 0x64 stores the byte, sets status bit 1 (input full) and sets status bit 3 to 1. The controller side sees the byte on `ctl_in_byte` with `ctl_in_is_cmd` = 1.
- R2: A host write to 0x60 stores the byte, sets status bit 1 and clears status bit 3 to 0. `ctl_in_is_cmd` reads 0.
- R3: `ctl_in_take` clears status bit 1 and leaves bit 3 as it was. A host write while bit 1 is 1 replaces the byte and sets bit 3 from the new address. If a host write and a take fall in the same cycle, bit 1 stays 1.
- R4: `ctl_out_load` stores a byte and sets status bit 0. A host read of 0x60 returns the stored byte and clears bit 0. A read of 0x60 while bit 0 is 0 returns the last loaded byte again.
- R5: If a load and a host read of 0x60 fall in the same cycle, the read returns the old byte, bit 0 stays 1, and the new byte is held.
- R6: Status bit 4 takes the value of `inhibit_sw_n` only in a cycle with `ctl_out_load`. At all other times it holds its value.
- R7: Status bit 2 is 0 after reset. `ctl_selftest_ok` sets it. `ctl_sysflag_wr` writes it with `ctl_sysflag_val`, and the write wins over a self-test pulse in the same cycle.
- R8: A result with `ctl_tx_no_resp` = 1 sets both status bits 5 and 6. A result reported while no transmit is pending is ignored.
- R9: A result with `ctl_tx_par_err` = 1 and no-response = 0 sets both status bits 5 and 7. A result with neither set leaves bits 5 to 7 at 0.
- R10: `ctl_tx_start` clears status bits 5, 6 and 7.
- R11: A host read of 0x64 changes no state. A read of any other address returns 0 and changes no state. A write to any other address is ignored.
- R12: After reset the status byte is 0x00 and the output buffer holds 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_addr | input | 8 | host I/O address |
| bus_wr | input | 1 | host write strobe, one cycle per write |
| bus_rd | input | 1 | host read strobe, one cycle per read |
| bus_wdata | input | 8 | host write data |
| bus_rdata | output | 8 | host read data, combinational from address |
| ctl_in_take | input | 1 | controller consumes the input byte |
| ctl_in_byte | output | 8 | buffered host byte |
| ctl_in_is_cmd | output | 1 | buffered byte came through the command port |
| ctl_in_full | output | 1 | input buffer holds an unconsumed byte |
| ctl_out_load | input | 1 | controller loads a byte for the host |
| ctl_out_byte | input | 8 | byte to load |
| inhibit_sw_n | input | 1 | keyboard inhibit switch, 0 = inhibited |
| ctl_selftest_ok | input | 1 | self test passed |
| ctl_sysflag_wr | input | 1 | write the system flag |
| ctl_sysflag_val | input | 1 | value for the system flag |
| ctl_tx_start | input | 1 | a serial transmit begins |
| ctl_tx_done | input | 1 | transmit result valid |
| ctl_tx_no_resp | input | 1 | result: no response within the limit |
| ctl_tx_par_err | input | 1 | result: response had a parity error |
| status | output | 8 | current status byte |

## Verification
The bench goes after the same-cycle collisions. If a take beat a host write, the new command would be lost with bit 1 at 0. If a host read beat a load, bit 0 would be 0 while the new byte sat unseen. It checks that the inhibit sample does not follow the switch between loads; a design that tracked the switch freely would change bit 4 with no byte loaded. It also checks the paired error flags, the clearing on a new transmit, and that a stray result with nothing pending leaves the flags at 0. Finally it reads the empty output buffer and the status port more than once to catch reads that disturb state.

// File: rtl/kbc_host_pkg.sv
package kbc_host_pkg;

    // status byte bit positions
    localparam int ST_OBF = 0;
    localparam int ST_IBF = 1;
    localparam int ST_SYS = 2;
    localparam int ST_CD  = 3;
    localparam int ST_INH = 4;
    localparam int ST_TTO = 5;
    localparam int ST_RTO = 6;
    localparam int ST_PAR = 7;
    localparam int ST_W   = 8;

    typedef enum logic {IB_EMPTY, IB_HELD} ib_state_e;
    typedef enum logic {OB_EMPTY, OB_HELD} ob_state_e;
    typedef enum logic {TX_IDLE, TX_WAIT} tx_state_e;

    typedef struct packed {
        logic par;
        logic rto;
        logic tto;
    } tx_flags_t;

endpackage

// File: rtl/kbc_in_buf.sv
module kbc_in_buf
    import kbc_host_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_is_cmd,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              ctl_take,
    output logic [DATA_W-1:0] held_byte,
    output logic              held_is_cmd,
    output logic              full
);

    ib_state_e         state_q, state_d;
    logic [DATA_W-1:0] byte_q;
    logic              cmd_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IB_EMPTY: if (host_wr) state_d = IB_HELD;
            IB_HELD:  if (ctl_take && !host_wr) state_d = IB_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IB_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            cmd_q  <= 1'b0;
        end else if (host_wr) begin
            byte_q <= host_wdata;
            cmd_q  <= host_is_cmd;
        end
    end

    always_comb begin
        full        = (state_q == IB_HELD);
        held_byte   = byte_q;
        held_is_cmd = cmd_q;
    end

    assert_wr_fills_R1: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> full && held_byte == $past(host_wdata));

    assert_cmd_follows_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> held_is_cmd == $past(host_is_cmd));

    assert_take_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_take && !host_wr |=> !full);

endmodule

// File: rtl/kbc_out_buf.sv
module kbc_out_buf
    import kbc_host_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_load,
    input  logic [DATA_W-1:0] ctl_byte,
    input  logic              inhibit_sw_n,
    input  logic              host_take,
    output logic [DATA_W-1:0] out_byte,
    output logic              full,
    output logic              inh_sample
);

    ob_state_e         state_q, state_d;
    logic [DATA_W-1:0] byte_q;
    logic              inh_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OB_EMPTY: if (ctl_load) state_d = OB_HELD;
            OB_HELD:  if (host_take && !ctl_load) state_d = OB_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OB_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            inh_q  <= 1'b0;
        end else if (ctl_load) begin
            byte_q <= ctl_byte;
            inh_q  <= inhibit_sw_n;
        end
    end

    always_comb begin
        full       = (state_q == OB_HELD);
        out_byte   = byte_q;
        inh_sample = inh_q;
    end

    assert_load_fills_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_load |=> full && out_byte == $past(ctl_byte));

    assert_read_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        host_take && !ctl_load |=> !full);

    assert_inh_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_load |=> $stable(inh_sample));

endmodule

// File: rtl/kbc_tx_status.sv
module kbc_tx_status
    import kbc_host_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tx_start,
    input  logic      tx_done,
    input  logic      no_resp,
    input  logic      par_err,
    output tx_flags_t flags
);

    tx_state_e state_q, state_d;
    tx_flags_t flags_q;
    logic      accept;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (tx_start) state_d = TX_WAIT;
            TX_WAIT: if (tx_done && !tx_start) state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    assign accept = (state_q == TX_WAIT) && tx_done && !tx_start;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (tx_start) begin
            flags_q <= '0;
        end else if (accept) begin
            if (no_resp) begin
                flags_q.tto <= 1'b1;
                flags_q.rto <= 1'b1;
            end else if (par_err) begin
                flags_q.tto <= 1'b1;
                flags_q.par <= 1'b1;
            end
        end
    end

    always_comb flags = flags_q;

    assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> flags == '0);

    assert_rto_paired_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flags.rto |-> flags.tto);

    assert_par_paired_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flags.par |-> flags.tto && !flags.rto);

    assert_idle_result_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == TX_IDLE && !tx_start |=> $stable(flags));

endmodule

// File: rtl/kbc_host_port.sv
module kbc_host_port
    import kbc_host_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter int              DATA_W    = 8,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h60,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ctl_in_take,
    output logic [DATA_W-1:0] ctl_in_byte,
    output logic              ctl_in_is_cmd,
    output logic              ctl_in_full,
    input  logic              ctl_out_load,
    input  logic [DATA_W-1:0] ctl_out_byte,
    input  logic              inhibit_sw_n,
    input  logic              ctl_selftest_ok,
    input  logic              ctl_sysflag_wr,
    input  logic              ctl_sysflag_val,
    input  logic              ctl_tx_start,
    input  logic              ctl_tx_done,
    input  logic              ctl_tx_no_resp,
    input  logic              ctl_tx_par_err,
    output logic [ST_W-1:0]   status
);

    logic              hit_data, hit_cmd;
    logic              host_wr_hit, host_data_rd;
    logic [DATA_W-1:0] out_byte;
    logic              out_full, inh_sample;
    logic              sys_q;
    tx_flags_t         tx_flags;

    always_comb begin
        hit_data     = (bus_addr == DATA_ADDR);
        hit_cmd      = (bus_addr == CMD_ADDR);
        host_wr_hit  = bus_wr && (hit_data || hit_cmd);
        host_data_rd = bus_rd && hit_data;
    end

    kbc_in_buf #(.DATA_W(DATA_W)) u_in (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr     (host_wr_hit),
        .host_is_cmd (hit_cmd),
        .host_wdata  (bus_wdata),
        .ctl_take    (ctl_in_take),
        .held_byte   (ctl_in_byte),
        .held_is_cmd (ctl_in_is_cmd),
        .full        (ctl_in_full)
    );

    kbc_out_buf #(.DATA_W(DATA_W)) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_load     (ctl_out_load),
        .ctl_byte     (ctl_out_byte),
        .inhibit_sw_n (inhibit_sw_n),
        .host_take    (host_data_rd),
        .out_byte     (out_byte),
        .full         (out_full),
        .inh_sample   (inh_sample)
    );

    kbc_tx_status u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_start (ctl_tx_start),
        .tx_done  (ctl_tx_done),
        .no_resp  (ctl_tx_no_resp),
        .par_err  (ctl_tx_par_err),
        .flags    (tx_flags)
    );

    // system flag: firmware write takes priority over the self-test pulse
    always_ff @(posedge clk) begin
        if (!rst_n)               sys_q <= 1'b0;
        else if (ctl_sysflag_wr)  sys_q <= ctl_sysflag_val;
        else if (ctl_selftest_ok) sys_q <= 1'b1;
    end

    always_comb begin
        status         = '0;
        status[ST_OBF] = out_full;
        status[ST_IBF] = ctl_in_full;
        status[ST_SYS] = sys_q;
        status[ST_CD]  = ctl_in_is_cmd;
        status[ST_INH] = inh_sample;
        status[ST_TTO] = tx_flags.tto;
        status[ST_RTO] = tx_flags.rto;
        status[ST_PAR] = tx_flags.par;
    end

    always_comb begin
        if (hit_cmd)       bus_rdata = DATA_W'(status);
        else if (hit_data) bus_rdata = out_byte;
        else               bus_rdata = '0;
    end

    assert_selftest_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_selftest_ok && !ctl_sysflag_wr |=> status[ST_SYS]);

    assert_sysflag_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_sysflag_wr |=> status[ST_SYS] == $past(ctl_sysflag_val));

    assert_status_read_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && hit_cmd && !ctl_out_load |=> status[ST_OBF] == $past(status[ST_OBF]));

    assert_stray_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && !hit_data && !hit_cmd && !ctl_in_take |=> $stable(ctl_in_byte) && $stable(ctl_in_full));

endmodule

// File: tb/test_kbc_host_port.sv
module test_kbc_host_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ctl_in_take = 1'b0;
    logic [7:0] ctl_in_byte;
    logic       ctl_in_is_cmd, ctl_in_full;
    logic       ctl_out_load = 1'b0;
    logic [7:0] ctl_out_byte = 8'h00;
    logic       inhibit_sw_n = 1'b1;
    logic       ctl_selftest_ok = 1'b0, ctl_sysflag_wr = 1'b0, ctl_sysflag_val = 1'b0;
    logic       ctl_tx_start = 1'b0, ctl_tx_done = 1'b0;
    logic       ctl_tx_no_resp = 1'b0, ctl_tx_par_err = 1'b0;
    logic [7:0] status;

    always #4 clk = ~clk;

    kbc_host_port i_kbc_host_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_in_take(ctl_in_take),
        .ctl_in_byte(ctl_in_byte), .ctl_in_is_cmd(ctl_in_is_cmd), .ctl_in_full(ctl_in_full),
        .ctl_out_load(ctl_out_load), .ctl_out_byte(ctl_out_byte), .inhibit_sw_n(inhibit_sw_n),
        .ctl_selftest_ok(ctl_selftest_ok), .ctl_sysflag_wr(ctl_sysflag_wr),
        .ctl_sysflag_val(ctl_sysflag_val), .ctl_tx_start(ctl_tx_start), .ctl_tx_done(ctl_tx_done),
        .ctl_tx_no_resp(ctl_tx_no_resp), .ctl_tx_par_err(ctl_tx_par_err), .status(status)
    );

    typedef struct {
        string      tag;
        logic [7:0] val;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int   checks = 0;
    int   fails = 0;

    // reference model of the status bits, kept from the requirements
    logic m_par = 0, m_rto = 0, m_tto = 0, m_inh = 0, m_cd = 0, m_sys = 0, m_ibf = 0, m_obf = 0;
    logic [7:0] m_ibyte = 0, m_obyte = 0;

    function automatic logic [7:0] exp_status();
        return {m_par, m_rto, m_tto, m_inh, m_cd, m_sys, m_ibf, m_obf};
    endfunction

    // monitor: every host read cycle is compared against the next queued item
    always @(negedge clk) begin
        if (rst_n && bus_rd) begin
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL unexpected read: actual %02h expected none", bus_rdata);
            end else begin
                e = q.pop_front();
                if (bus_rdata !== e.val) begin
                    fails++;
                    $display("FAIL %s: actual %02h expected %02h", e.tag, bus_rdata, e.val);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic host_write(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
        if (a == 8'h60 || a == 8'h64) begin
            m_ibf = 1; m_cd = (a == 8'h64); m_ibyte = d;
        end
    endtask

    task automatic read_status(input string tag);
        bus_addr = 8'h64; bus_rd = 1'b1;
        q.push_back('{tag, exp_status()});
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic read_data(input string tag);
        bus_addr = 8'h60; bus_rd = 1'b1;
        q.push_back('{tag, m_obyte});
        tick();
        bus_rd = 1'b0;
        m_obf = 0;
    endtask

    task automatic take_in();
        ctl_in_take = 1'b1;
        tick();
        ctl_in_take = 1'b0;
        m_ibf = 0;
    endtask

    task automatic load_out(input logic [7:0] d);
        ctl_out_byte = d; ctl_out_load = 1'b1;
        tick();
        ctl_out_load = 1'b0;
        m_obf = 1; m_obyte = d; m_inh = inhibit_sw_n;
    endtask

    task automatic check_in(input string tag);
        checks++;
        if (ctl_in_byte !== m_ibyte || ctl_in_is_cmd !== m_cd) begin
            fails++;
            $display("FAIL %s: actual %02h/%0b expected %02h/%0b",
                     tag, ctl_in_byte, ctl_in_is_cmd, m_ibyte, m_cd);
        end
    endtask

    task automatic tx_result(input logic nr, input logic pe, input logic pending);
        ctl_tx_no_resp = nr; ctl_tx_par_err = pe; ctl_tx_done = 1'b1;
        tick();
        ctl_tx_done = 1'b0; ctl_tx_no_resp = 1'b0; ctl_tx_par_err = 1'b0;
        if (pending) begin
            if (nr) begin m_tto = 1; m_rto = 1; end
            else if (pe) begin m_tto = 1; m_par = 1; end
        end
    endtask

    task automatic tx_start();
        ctl_tx_start = 1'b1;
        tick();
        ctl_tx_start = 1'b0;
        m_tto = 0; m_rto = 0; m_par = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R12 reset state
        read_status("R12 status after reset");
        read_data("R12 output byte after reset");
        read_status("R12 empty read keeps obf 0");

        // R1 command port write
        host_write(8'h64, 8'hAA);
        read_status("R1 status after command write");
        check_in("R1 command byte to controller");

        // R3 take clears input full, command flag stays
        take_in();
        read_status("R3 status after take");

        // R2 data port write
        host_write(8'h60, 8'h55);
        read_status("R2 status after data write");
        check_in("R2 data byte to controller");

        // R3 overwrite while full
        host_write(8'h64, 8'h33);
        read_status("R3 status after overwrite");
        check_in("R3 overwritten byte");

        // R3 write and take in the same cycle
        bus_addr = 8'h60; bus_wdata = 8'h44; bus_wr = 1'b1; ctl_in_take = 1'b1;
        tick();
        bus_wr = 1'b0; ctl_in_take = 1'b0;
        m_ibf = 1; m_cd = 0; m_ibyte = 8'h44;
        read_status("R3 write beats take");
        check_in("R3 byte after collision");
        take_in();
        read_status("R3 status after final take");

        // R4 / R6 output load with switch not inhibited
        inhibit_sw_n = 1'b1;
        load_out(8'h5A);
        read_status("R4 R6 status after load");
        inhibit_sw_n = 1'b0;
        tick();
        read_status("R6 switch change without load ignored");
        read_data("R4 data read");
        read_status("R4 obf cleared by read");
        read_data("R4 repeat read of empty buffer");
        read_status("R4 status after empty read");

        // R6 sample inhibited value
        load_out(8'h77);
        read_status("R6 inhibited sample");

        // R5 load and read in the same cycle
        bus_addr = 8'h60; bus_rd = 1'b1; ctl_out_byte = 8'hC3; ctl_out_load = 1'b1;
        q.push_back('{"R5 read returns old byte", 8'h77});
        tick();
        bus_rd = 1'b0; ctl_out_load = 1'b0;
        m_obf = 1; m_obyte = 8'hC3; m_inh = inhibit_sw_n;
        read_status("R5 obf stays set");
        read_data("R5 new byte held");
        read_status("R5 obf clear after read");

        // R7 system flag
        ctl_selftest_ok = 1'b1; tick(); ctl_selftest_ok = 1'b0; m_sys = 1;
        read_status("R7 self test sets flag");
        ctl_selftest_ok = 1'b1; ctl_sysflag_wr = 1'b1; ctl_sysflag_val = 1'b0;
        tick();
        ctl_selftest_ok = 1'b0; ctl_sysflag_wr = 1'b0; m_sys = 0;
        read_status("R7 write wins over self test");
        ctl_sysflag_wr = 1'b1; ctl_sysflag_val = 1'b1; tick(); ctl_sysflag_wr = 1'b0; m_sys = 1;
        read_status("R7 write sets flag");

        // R8 / R9 / R10 transmit results
        tx_result(1'b1, 1'b0, 1'b0);
        read_status("R8 result with no transmit ignored");
        tx_start();
        tx_result(1'b1, 1'b0, 1'b1);
        read_status("R8 no response pair");
        tx_start();
        read_status("R10 start clears flags");
        tx_result(1'b0, 1'b1, 1'b1);
        read_status("R9 parity pair");
        tx_start();
        tx_result(1'b0, 1'b0, 1'b1);
        read_status("R9 clean result leaves flags clear");

        // R11 side-effect-free and stray accesses
        load_out(8'h99);
        read_status("R11 status read one");
        read_status("R11 status read two keeps obf");
        host_write(8'h61, 8'hEE);
        read_status("R11 stray write ignored");
        check_in("R11 input byte untouched");
        bus_addr = 8'h62; bus_rd = 1'b1;
        q.push_back('{"R11 stray read returns zero", 8'h00});
        tick();
        bus_rd = 1'b0;
        read_status("R11 stray read changes nothing");
        read_data("R11 output byte intact");

        tick();
        if (q.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard drain: actual %0d expected 0", q.size());
        end
        finish_run();
    end

endmodule